// File: doc/BRIEF.md
# Symmetric decade frequency divider

This block turns a squared 10 MHz reference clock into two square-wave outputs with an exact 50% duty cycle: a 5 MHz output from a divide-by-2 stage and a 1 MHz output from a divide-by-10 stage. A third output gives a pulse one reference cycle wide at the start of every 1 MHz period. Downstream logic can use this pulse to align work to the slow clock without having to detect its edge.

The decade stage is a synchronous counter that runs through an offset window instead of starting at zero. With the default 4-bit width the window is 3 up to 12. Its most significant bit is therefore already the 1 MHz square wave: low for five counts and high for five counts, with no extra toggle stage. Every output comes straight from a flop clocked by the reference clock, so all edges line up with it.

A synchronous reset loads the start of the window. An enable freezes the counter and the halver when it is low. Any count outside the window, whether below the start or at or above the terminal value, returns to the cycle on its own within a few edges.

Top module: `refdiv_top`

## Requirements
- R1: On a clock edge with `rst` high, the counter loads its reset value (3 by default) and `div2_o`, `div10_o` and `sync_o` all read 0 after that edge. Reset takes priority over `en`.
- R2: After reset is released with `en` high, `div10_o` first goes high on the 5th enabled edge. From then on it is high for exactly 5 enabled edges and low for exactly 5 enabled edges. It is bit 3 of a counter that steps by one through 3..12.
- R3: An enabled edge taken at a count of 12 or above (13, 14 and 15 included) loads 3. With the default width this terminal test needs only counter bits 3 and 2 both set.
- R4: A count below 3 (0, 1 or 2) steps up by one on each enabled edge until it reaches 3, and normal cycling follows from there.
- R5: `div2_o` inverts on every enabled edge, so it is high for 1 and low for 1 enabled edge.
- R6: Starting from a reset to count 3, each rising edge of `div10_o` occurs on the same reference edge as a rising edge of `div2_o`.
- R7: `sync_o` is high for exactly one cycle, the cycle in which `div10_o` has just risen (count 7 to 8). It is low at every other time.
- R8: While `en` is low, the counter, `div10_o` and `div2_o` keep their values, and `sync_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Squared 10 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| div2_o | output | 1 | Reference divided by 2, 50% duty |
| div10_o | output | 1 | Reference divided by 10, 50% duty |
| sync_o | output | 1 | One-cycle pulse at each rise of `div10_o` |

## Verification
Every output is a flop clocked by the reference clock. Each result is therefore due exactly one edge after the inputs that cause it: the bench changes `rst` and `en` just after a rising edge, the next rising edge acts on them, and the outputs are sampled at the falling edge that follows. The driver task pushes its expected output only after the acting edge has passed, and the monitor pops and compares at the falling edge, so each comparison falls half a cycle after the output was due. The recovery test counts falling edges from the reset edge and predicts the first rise of the 1 MHz output from each illegal start value: 8 minus the value for starts 0 to 2, and 6 edges for starts 13 to 15.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Default geometry: 4-bit counter, half period of 5 reference cycles.
    localparam int DEF_CNT_W = 4;
    localparam int DEF_HALF  = 5;

    // Bundle of the three block outputs.
    typedef struct packed {
        logic half_clk;
        logic decade_clk;
        logic period_mark;
    } refdiv_out_t;

endpackage

// File: rtl/refdiv_decade.sv
module refdiv_decade #(
    parameter int CNT_W       = refdiv_pkg::DEF_CNT_W,
    parameter int HALF        = refdiv_pkg::DEF_HALF,
    parameter int RESET_COUNT = (1 << (CNT_W - 1)) - HALF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);
    // The window is placed so that the top bit flips exactly halfway through it.
    localparam int START = (1 << (CNT_W - 1)) - HALF;
    localparam int TERM  = START + 2 * HALF - 1;
    localparam logic [CNT_W-1:0] START_V = CNT_W'(START);
    localparam logic [CNT_W-1:0] TERM_V  = CNT_W'(TERM);
    localparam logic [CNT_W-1:0] RST_V   = CNT_W'(RESET_COUNT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = RST_V;
        end else if (en) begin
            // With the default window this test needs only bits 3 and 2.
            if (st_q.cnt >= TERM_V) begin
                st_d.cnt = START_V;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (st_q.cnt == RST_V));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && st_q.cnt >= START_V && st_q.cnt < TERM_V)
            |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (en && st_q.cnt >= TERM_V) |=> (st_q.cnt == START_V));

    p_climb_r4: assert property (@(posedge clk) disable iff (rst)
        (en && st_q.cnt < START_V) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    p_hold_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.cnt));

endmodule

// File: rtl/refdiv_half.sv
module refdiv_half (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic half_o
);
    typedef struct packed {
        logic tog;
    } half_state_t;

    half_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.tog = 1'b0;
        end else if (en) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign half_o = st_q.tog;

    p_half_reset_r1: assert property (@(posedge clk)
        rst |=> !half_o);

    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        en |=> (half_o != $past(half_o)));

    p_hold_half_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(half_o));

endmodule

// File: rtl/refdiv_marker.sv
module refdiv_marker #(
    parameter int CNT_W = refdiv_pkg::DEF_CNT_W,
    parameter int HALF  = refdiv_pkg::DEF_HALF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             mark_o
);
    // The count at which the counter's top bit first reads 1.
    localparam int MID = 1 << (CNT_W - 1);
    localparam logic [CNT_W-1:0] MID_V  = CNT_W'(MID);
    localparam logic [CNT_W-1:0] PRE_V  = CNT_W'(MID - 1);

    typedef struct packed {
        logic mark;
    } mark_state_t;

    mark_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.mark = !rst && en && (cnt_i == PRE_V);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mark_o = st_q.mark;

    p_mark_at_mid_r7: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> (cnt_i == MID_V));

    p_mark_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mark_o);

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
    parameter int CNT_W       = refdiv_pkg::DEF_CNT_W,
    parameter int HALF        = refdiv_pkg::DEF_HALF,
    parameter int RESET_COUNT = (1 << (CNT_W - 1)) - HALF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic div2_o,
    output logic div10_o,
    output logic sync_o
);
    localparam int START = (1 << (CNT_W - 1)) - HALF;

    logic [CNT_W-1:0]        count;
    refdiv_pkg::refdiv_out_t outs;

    refdiv_decade #(
        .CNT_W       (CNT_W),
        .HALF        (HALF),
        .RESET_COUNT (RESET_COUNT)
    ) u_decade (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .cnt_o (count)
    );

    refdiv_half u_half (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .half_o (outs.half_clk)
    );

    refdiv_marker #(
        .CNT_W (CNT_W),
        .HALF  (HALF)
    ) u_marker (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt_i  (count),
        .mark_o (outs.period_mark)
    );

    // The slow square wave is the counter's top bit, itself a flop output.
    assign outs.decade_clk = count[CNT_W-1];

    assign div2_o  = outs.half_clk;
    assign div10_o = outs.decade_clk;
    assign sync_o  = outs.period_mark;

    p_rise_marked_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(div10_o) |-> sync_o);

    generate
        if (RESET_COUNT == START) begin : g_aligned
            p_edges_align_r6: assert property (@(posedge clk) disable iff (rst)
                $rose(div10_o) |-> $rose(div2_o));
        end
    endgenerate

endmodule

// File: tb/refdiv_top_test.sv
module refdiv_top_test;

    localparam int N_ILL = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic div2_o, div10_o, sync_o;

    logic [N_ILL-1:0] ill_div2, ill_div10, ill_sync;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    refdiv_top uut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .div2_o  (div2_o),
        .div10_o (div10_o),
        .sync_o  (sync_o)
    );

    function automatic int ill_val(int i);
        return (i < 3) ? i : i + 10;
    endfunction

    for (genvar g = 0; g < N_ILL; g++) begin : g_ill
        refdiv_top #(.RESET_COUNT(ill_val(g))) u_ill (
            .clk     (clk),
            .rst     (rst),
            .en      (1'b1),
            .div2_o  (ill_div2[g]),
            .div10_o (ill_div10[g]),
            .sync_o  (ill_sync[g])
        );
    end

    // Scoreboard item: expected outputs after one acting edge.
    localparam int K_RST  = 0;
    localparam int K_HOLD = 1;
    localparam int K_RUN  = 2;

    typedef struct {
        logic d2;
        logic d10;
        logic sy;
        int   kind;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state: phase 0..9 within the slow period, halver level.
    int   ph = 0;
    logic m2 = 1'b0;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic e);
        exp_t it;
        rst = r;
        en  = e;
        @(posedge clk);
        #1;
        if (r) begin
            ph = 0; m2 = 1'b0;
            it.sy = 1'b0; it.kind = K_RST;
        end else if (e) begin
            ph = (ph + 1) % 10; m2 = ~m2;
            it.sy = (ph == 5); it.kind = K_RUN;
        end else begin
            it.sy = 1'b0; it.kind = K_HOLD;
        end
        it.d2  = m2;
        it.d10 = (ph >= 5);
        exp_q.push_back(it);
    endtask

    // Monitor: compare half a cycle after the outputs became due.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            if (it.kind == K_RST) begin
                chk("R1", "div2",  div2_o,  it.d2);
                chk("R1", "div10", div10_o, it.d10);
                chk("R1", "sync",  sync_o,  it.sy);
            end else if (it.kind == K_HOLD) begin
                chk("R8", "div2",  div2_o,  it.d2);
                chk("R8", "div10", div10_o, it.d10);
                chk("R8", "sync",  sync_o,  it.sy);
            end else begin
                chk("R2", "div10", div10_o, it.d10);
                chk(it.sy ? "R6" : "R5", "div2", div2_o, it.d2);
                chk("R7", "sync",  sync_o,  it.sy);
            end
        end
    end

    // Recovery from every illegal reset count (R3: 13..15, R4: 0..2).
    task automatic recovery();
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int k = 0; k < 36; k++) begin
            @(negedge clk);
            for (int g = 0; g < N_ILL; g++) begin
                int    v, kr;
                logic  e10, esy;
                string tag;
                v   = ill_val(g);
                kr  = (v <= 2) ? 8 - v : 6;
                tag = (v <= 2) ? "R4" : "R3";
                if (k < kr) begin
                    e10 = (k == 0) ? (v >= 8) : 1'b0;
                    esy = 1'b0;
                end else begin
                    e10 = (((k - kr) % 10) < 5);
                    esy = (((k - kr) % 10) == 0);
                end
                chk(tag, "recover div10", ill_div10[g], e10);
                chk(tag, "recover sync",  ill_sync[g],  esy);
                chk("R5", "recover div2", ill_div2[g], logic'(k % 2));
            end
        end
    endtask

    initial begin
        // R1: reset held for several edges.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        // R2, R5, R6, R7: free run over many slow periods.
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1);
        // R8: stall exactly at the count just before the rising edge.
        while (ph != 4) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // R8: irregular enable pattern.
        for (int i = 0; i < 90; i++) step(1'b0, ((i % 7) != 3) && ((i % 11) != 5));
        // R1: reset in mid-period, with enable low (reset wins).
        for (int i = 0; i < 13; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        for (int i = 0; i < 45; i++) step(1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        recovery();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule